// File: doc/BRIEF.md
# Clock-Gating Control Register File

This block is a word-addressed register bank for a system-control I/O region. It is reached through a simple 32-bit little-endian register bus. Every word is loaded with its own reset value. Most words are plain read/write storage. Two words hold clock-stop vectors, and these have special write rules. A write at the word's own offset sets bits by OR. A write to a companion alias one word above flips bits in the control word by XOR. The companion alias word itself never changes.

Both clock-stop words are driven out as 32-bit gating vectors, where a set bit means that clock is stopped. A 3-bit peripheral-clock divider field in the clock-select word sets a combined divide ratio. The block applies that ratio to an input PLL frequency to give the derived bus-clock frequency. Every access gets a response one cycle later. Illegal access shapes are flagged, and out-of-range accesses read as zero.

Top module: `clk_gate_regfile`

## Requirements
- R1: After reset, every word holds its reset value and all other words hold zero. The reset values are: word 0x00 = 0x06000003, 0x10 = 0x00000504, 0x240 = 0xFFFF8400, 0x260 = 0x00005F30, 0x280 = 0x86900000, 0x284 = 0x00400000, 0x300 = 0x10000027, 0x330 = 0x00014506.
- R2: An access is legal only when req_size is 1, 2, 4 or 8 and req_addr is a multiple of req_size. An illegal access gets resp_err=1 and resp_rdata=0, and it changes no register.
- R3: A legal in-range write to any ordinary word stores the low 32 bits of req_wdata into word req_addr>>2, whatever the access size. A read returns the whole stored word.
- R4: A write to clock-stop word 0x240 or 0x260 ORs the data into the stored value.
- R5: A write to alias 0x244 or 0x264 XORs the data into the word one below it. The alias word keeps its value.
- R6: When the word index req_addr>>2 is at or above NWORDS, the access is out of range. A read then returns 0 with resp_err=0, and a write changes no register.
- R7: resp_valid is 1 exactly one cycle after each request and 0 otherwise. Read data is the value stored before any write in that same cycle.
- R8: gate_a always equals word 0x240 and gate_b always equals word 0x260. A set bit means the clock is stopped.
- R9: The divider field is bits [25:23] of word 0x280. div_ratio equals 2*(field+1), and bus_clk_hz equals floor(pll_hz / div_ratio).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data; only the low 32 bits are used |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_err | output | 1 | Illegal access shape |
| resp_rdata | output | 32 | Read data |
| gate_a | output | 32 | First clock-stop vector |
| gate_b | output | 32 | Second clock-stop vector |
| pll_hz | input | 32 | PLL frequency |
| div_ratio | output | 5 | Combined bus-clock divide ratio |
| bus_clk_hz | output | 32 | Derived bus-clock frequency |

## Verification
The hardest case to reach is the interaction between a clock-stop word and its alias. The alias must flip bits one word below it while its own storage stays untouched. A bench that only writes and reads back ordinary words would never see a wrong target or a stray alias update. The bench therefore sweeps writes over every word in a reduced 256-word configuration, using a bench-side model that applies the OR and XOR rules. It then reads back every word, including the aliases. It also checks that an out-of-range write does not wrap onto the in-range word with the same low index bits.

// File: rtl/clk_gate_regfile.sv
module clk_gate_regfile #(
  parameter int NWORDS = 1024,
  parameter int ADDR_W = 16,
  parameter int DIV_LSB = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [31:0]       resp_rdata,
  output logic [31:0]       gate_a,
  output logic [31:0]       gate_b,
  input  logic [31:0]       pll_hz,
  output logic [4:0]        div_ratio,
  output logic [31:0]       bus_clk_hz
);
  localparam int AW = $clog2(NWORDS);
  localparam int IW = ADDR_W - 2;
  localparam int STOP_A = 'h240 >> 2;
  localparam int STOP_B = 'h260 >> 2;
  localparam int CSEL   = 'h280 >> 2;

  function automatic logic [31:0] init_word(int i);
    case (i)
      CSEL:       return 32'h8690_0000;
      STOP_B:     return 32'h0000_5F30;
      0:          return 32'h0600_0003;
      'h300 >> 2: return 32'h1000_0027;
      STOP_A:     return 32'hFFFF_8400;
      'h10 >> 2:  return 32'h0000_0504;
      'h330 >> 2: return 32'h0001_4506;
      'h284 >> 2: return 32'h0040_0000;
      default:    return 32'h0;
    endcase
  endfunction

  logic [31:0] regs [NWORDS];
  logic [IW-1:0] widx_full;
  logic [AW-1:0] widx;
  logic shape_ok, in_range, wr_ok;
  logic [31:0] wd;

  assign widx_full = req_addr[ADDR_W-1:2];
  assign widx      = widx_full[AW-1:0];
  assign in_range  = 32'(widx_full) < 32'(NWORDS);
  assign wd        = req_wdata[31:0];

  always_comb begin
    case (req_size)
      4'd1:    shape_ok = 1'b1;
      4'd2:    shape_ok = req_addr[0] == 1'b0;
      4'd4:    shape_ok = req_addr[1:0] == 2'b00;
      4'd8:    shape_ok = req_addr[2:0] == 3'b000;
      default: shape_ok = 1'b0;
    endcase
  end

  assign wr_ok = req_valid && req_write && shape_ok && in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) regs[i] <= init_word(i);
    end else if (wr_ok) begin
      if (32'(widx) == STOP_A || 32'(widx) == STOP_B)
        regs[widx] <= regs[widx] | wd;
      else if (32'(widx) == STOP_A + 1 || 32'(widx) == STOP_B + 1)
        regs[widx - 1'b1] <= regs[widx - 1'b1] ^ wd;
      else
        regs[widx] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= 32'h0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid && !shape_ok;
      resp_rdata <= (req_valid && !req_write && shape_ok && in_range) ? regs[widx] : 32'h0;
    end
  end

  assign gate_a = regs[STOP_A];
  assign gate_b = regs[STOP_B];

  logic [2:0] div_field;
  assign div_field  = regs[CSEL][DIV_LSB+2:DIV_LSB];
  assign div_ratio  = {1'b0, div_field, 1'b0} + 5'd2;
  assign bus_clk_hz = pll_hz / {27'd0, div_ratio};

  assert_bad_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !shape_ok |=> resp_err && resp_rdata == 32'h0);
  assert_stop_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && 32'(widx) == STOP_A |=> (gate_a & $past(wd)) == $past(wd));
  assert_alias_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && 32'(widx) == STOP_B + 1 |=> gate_b == $past(gate_b ^ wd));
  assert_alias_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && 32'(widx) == STOP_A + 1 |=> $stable(regs[STOP_A + 1]));
  assert_oob_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && !in_range |=> resp_rdata == 32'h0);
  assert_resp_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  assert_ratio_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_ratio[0] == 1'b0 && div_ratio >= 5'd2 && div_ratio <= 5'd16);
endmodule

// File: tb/sim_clk_gate_regfile.sv
module sim_clk_gate_regfile;
  localparam int NW = 256;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [3:0] req_size = 4;
  logic [63:0] req_wdata = 0;
  logic resp_valid, resp_err;
  logic [31:0] resp_rdata, gate_a, gate_b, bus_clk_hz;
  logic [31:0] pll_hz = 32'd600_000_000;
  logic [4:0] div_ratio;
  int n_chk = 0, n_bad = 0;
  logic [31:0] m [NW];
  logic got_v, got_e;
  logic [31:0] got_d;

  clk_gate_regfile #(.NWORDS(NW), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .gate_a(gate_a), .gate_b(gate_b), .pll_hz(pll_hz),
    .div_ratio(div_ratio), .bus_clk_hz(bus_clk_hz));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [11:0] a, input logic [3:0] s, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0;
    got_v = resp_valid; got_e = resp_err; got_d = resp_rdata;
  endtask

  task automatic mwrite(input int i, input logic [31:0] d);
    if (i == 144 || i == 152) m[i] = m[i] | d;
    else if (i == 145 || i == 153) m[i-1] = m[i-1] ^ d;
    else m[i] = d;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) m[i] = 0;
    m[0] = 32'h06000003; m[4] = 32'h00000504; m[144] = 32'hFFFF8400;
    m[152] = 32'h00005F30; m[160] = 32'h86900000; m[161] = 32'h00400000;
    m[192] = 32'h10000027; m[204] = 32'h00014506;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R7 idle resp_valid", {31'd0, resp_valid}, 0);
    for (int i = 0; i < NW; i++) begin
      acc(0, 12'(i*4), 4, 0);
      chk("R1 reset word", got_d, m[i]);
    end
    chk("R7 resp_valid", {31'd0, got_v}, 1);
    chk("R8 gate_a reset", gate_a, 32'hFFFF8400);
    chk("R8 gate_b reset", gate_b, 32'h00005F30);
    chk("R9 reset ratio", {27'd0, div_ratio}, 12);
    chk("R9 reset hz", bus_clk_hz, 600_000_000 / 12);

    acc(1, 12'h240, 4, 64'h1234_5678_0000_00FF); mwrite(144, 32'h000000FF);
    chk("R4 set", gate_a, 32'hFFFF84FF);
    acc(1, 12'h244, 4, 64'h0000_0400); mwrite(145, 32'h00000400);
    chk("R5 flip", gate_a, 32'hFFFF80FF);
    acc(0, 12'h244, 4, 0);
    chk("R5 alias kept", got_d, 32'h0);
    acc(1, 12'h264, 4, 64'hFFFF_0000); mwrite(153, 32'hFFFF0000);
    chk("R5 flip b", gate_b, 32'hFFFF5F30);
    acc(1, 12'h260, 4, 64'h0000_0001); mwrite(152, 32'h1);
    chk("R4 set b", gate_b, 32'hFFFF5F31);

    acc(1, 12'h00A, 4, 64'hDEAD);
    chk("R2 err misaligned", {31'd0, got_e}, 1);
    acc(1, 12'h008, 3, 64'hDEAD);
    chk("R2 err size3", {31'd0, got_e}, 1);
    acc(0, 12'h004, 8, 0);
    chk("R2 err size8 at 4", {31'd0, got_e}, 1);
    chk("R2 err rdata", got_d, 0);
    acc(0, 12'h008, 4, 0);
    chk("R2 dropped write", got_d, m[2]);
    acc(1, 12'h008, 8, 64'hAAAA_BBBB_CAFE_F00D); mwrite(2, 32'hCAFEF00D);
    acc(0, 12'h00B, 1, 0);
    chk("R3 size8 store / byte read", got_d, 32'hCAFEF00D);
    chk("R3 legal no err", {31'd0, got_e}, 0);
    acc(1, 12'h00D, 1, 64'h0000_0000_1111_2222); mwrite(3, 32'h11112222);

    acc(1, 12'h404, 4, 64'h5555_5555);
    chk("R6 oob write no err", {31'd0, got_e}, 0);
    acc(0, 12'h004, 4, 0);
    chk("R6 oob write dropped", got_d, m[1]);
    acc(0, 12'hFFC, 4, 0);
    chk("R6 oob read zero", got_d, 0);

    for (int i = 0; i < NW; i++) begin
      logic [31:0] d;
      d = 32'h5A000000 ^ (32'(i) * 32'h01030507);
      if (i == 160) d = 32'h00400000;
      acc(1, 12'(i*4), 4, {32'hFFFFFFFF, d}); mwrite(i, d);
    end
    for (int i = 0; i < NW; i++) begin
      acc(0, 12'(i*4), 4, 0);
      chk("R3 R4 R5 sweep readback", got_d, m[i]);
    end
    chk("R8 gate_a sweep", gate_a, m[144]);
    chk("R8 gate_b sweep", gate_b, m[152]);

    for (int f = 0; f < 8; f++) begin
      acc(1, 12'h280, 4, 64'(32'(f) << 23)); mwrite(160, 32'(f) << 23);
      chk("R9 ratio", {27'd0, div_ratio}, 32'(2 * (f + 1)));
      chk("R9 hz", bus_clk_hz, 600_000_000 / (2 * (f + 1)));
      pll_hz = 32'd25_000_007; #1;
      chk("R9 hz floor", bus_clk_hz, 25_000_007 / (2 * (f + 1)));
      pll_hz = 32'd600_000_000;
    end
    @(negedge clk); @(posedge clk); #1;
    chk("R7 idle after", {31'd0, resp_valid}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule